// File: doc/BRIEF.md
# Bus bridge translation monitor

This block sits beside a system-bus-to-peripheral-bus bridge: an AHB upstream slave face and an APB manager face. It watches the bridge's "in ACCESS phase" indication, the upstream ready and error-response outputs, and the APB manager signals. It checks the rules that tie the two faces together: a peripheral wait must stall the upstream side, and a peripheral error must become an upstream error on the beat that completes the transfer and on no other beat. It also checks that the APB request stays frozen while a transfer is in flight, that every transfer opens with an idle-enable phase, and that every ACCESS phase finishes within a bounded time.

Neither a per-bus protocol checker on the AHB side nor one on the APB side can see a broken mapping between the two buses. This monitor can. It is synthesizable, so it can stay in silicon or in an emulation build. Each rule owns one sticky violation bit. The bits hold until a synchronous clear or reset, and a summary output reports whether any bit is set.

Top module: `bridge_xchk`

## Requirements
- R1: Flag bit 0 (wait) is set after any cycle in which `in_access_i`=1, `pready_i`=0 and `hready_out_i`=1.
- R2: Flag bit 1 (error dropped) is set after any cycle in which `in_access_i`=1, `pready_i`=1, `pslverr_i`=1 and `hresp_err_i`=0.
- R3: Flag bit 2 (clean beat marked as error) is set after any cycle in which `in_access_i`=1, `pready_i`=1, `pslverr_i`=0 and `hresp_err_i`=1.
- R4: If a cycle has `psel_i`=1 and not both `penable_i` and `pready_i` are 1, then a different `paddr_i` or `pwrite_i` in the next cycle sets flag bit 3 (capture). A change that follows a completing cycle does not set it.
- R5: A transfer starts on a cycle with `psel_i`=1 whose previous cycle had `psel_i`=0 or was a completing cycle. If that first cycle has `penable_i`=1, flag bit 4 (setup gap) is set.
- R6: A cycle in ACCESS without completion (completion means `pready_i`=1 and `hready_out_i`=1 together) counts as a stall. MAX_WAIT stall cycles in a row set flag bit 5 (hang). The count restarts on every completion and on every cycle outside ACCESS.
- R7: Every flag bit is sticky. Once set, it stays 1 until a clear or reset.
- R8: `clr_i`=1 clears all flag bits at the next clock edge. The clear takes priority over a violation in the same cycle.
- R9: `any_o` is 1 exactly when at least one flag bit is 1.
- R10: While `rst_ni`=0 all flags are 0. The R4 and R5 comparisons are held off during the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the bridge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all flags |
| in_access_i | input | 1 | Bridge is in its ACCESS state |
| hready_out_i | input | 1 | Upstream ready driven by the bridge |
| hresp_err_i | input | 1 | Upstream response is ERROR |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable |
| pready_i | input | 1 | APB ready |
| pslverr_i | input | 1 | APB slave error |
| paddr_i | input | AW | APB address |
| pwrite_i | input | 1 | APB write strobe |
| flags_o | output | 6 | Sticky violation bits, indexed as in R1 to R6 |
| any_o | output | 1 | OR of all flag bits |

## Verification
The hardest situation to reach is the one at the edge of the hang window. ACCESS must stall for exactly MAX_WAIT-1 cycles and then complete, which must not set the flag, and it must stall for exactly MAX_WAIT cycles, which must. Random stimulus almost never holds ACCESS that long. The bench therefore runs a reduced MAX_WAIT and drives both stall lengths directly. It also drives completions that fall between stalls, so that the counter restart is exercised. A second edge is the first cycle after reset. There the bench holds a select with enable already high across the reset release, which exercises the hold-off.

// File: rtl/xchk_pkg.sv
`timescale 1ns/1ps
package xchk_pkg;
  localparam int NUM_RULES    = 6;
  localparam int RULE_WAIT    = 0;
  localparam int RULE_ERR     = 1;
  localparam int RULE_CLEAN   = 2;
  localparam int RULE_CAPTURE = 3;
  localparam int RULE_GAP     = 4;
  localparam int RULE_HANG    = 5;
endpackage

// File: rtl/xchk_beat.sv
`timescale 1ns/1ps
// single-cycle response-mapping rules
module xchk_beat (
  input  logic in_access_i,
  input  logic hready_out_i,
  input  logic hresp_err_i,
  input  logic pready_i,
  input  logic pslverr_i,
  output logic wait_o,
  output logic err_o,
  output logic clean_o
);
  logic done;
  assign done    = in_access_i && pready_i;
  assign wait_o  = in_access_i && !pready_i && hready_out_i;
  assign err_o   = done && pslverr_i && !hresp_err_i;
  assign clean_o = done && !pslverr_i && hresp_err_i;
endmodule

// File: rtl/xchk_seq.sv
`timescale 1ns/1ps
// cycle-to-cycle rules: request stability and setup gap
module xchk_seq #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          psel_i,
  input  logic          penable_i,
  input  logic          pready_i,
  input  logic [AW-1:0] paddr_i,
  input  logic          pwrite_i,
  output logic          capture_o,
  output logic          gap_o
);
  logic          armed_q, busy_q, wr_q;
  logic [AW-1:0] addr_q;
  logic          busy_d;

  assign busy_d = psel_i && !(penable_i && pready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      busy_q  <= busy_d;
      addr_q  <= paddr_i;
      wr_q    <= pwrite_i;
    end
  end

  assign capture_o = armed_q && busy_q && ((paddr_i != addr_q) || (pwrite_i != wr_q));
  assign gap_o     = armed_q && psel_i && !busy_q && penable_i;
endmodule

// File: rtl/xchk_watchdog.sv
`timescale 1ns/1ps
// bounded completion of the ACCESS phase
module xchk_watchdog #(
  parameter int MAX_WAIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_access_i,
  input  logic pready_i,
  input  logic hready_out_i,
  output logic hang_o
);
  localparam int CW = $clog2(MAX_WAIT + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_WAIT - 1);

  logic [CW-1:0] cnt_q;
  logic          stall;

  assign stall  = in_access_i && !(pready_i && hready_out_i);
  assign hang_o = stall && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!stall)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bridge_xchk.sv
`timescale 1ns/1ps
module bridge_xchk
  import xchk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int MAX_WAIT = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 in_access_i,
  input  logic                 hready_out_i,
  input  logic                 hresp_err_i,
  input  logic                 psel_i,
  input  logic                 penable_i,
  input  logic                 pready_i,
  input  logic                 pslverr_i,
  input  logic [AW-1:0]        paddr_i,
  input  logic                 pwrite_i,
  output logic [NUM_RULES-1:0] flags_o,
  output logic                 any_o
);
  logic [NUM_RULES-1:0] viol;

  xchk_beat u_beat (
    .in_access_i (in_access_i),
    .hready_out_i(hready_out_i),
    .hresp_err_i (hresp_err_i),
    .pready_i    (pready_i),
    .pslverr_i   (pslverr_i),
    .wait_o      (viol[RULE_WAIT]),
    .err_o       (viol[RULE_ERR]),
    .clean_o     (viol[RULE_CLEAN])
  );

  xchk_seq #(.AW(AW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pready_i (pready_i),
    .paddr_i  (paddr_i),
    .pwrite_i (pwrite_i),
    .capture_o(viol[RULE_CAPTURE]),
    .gap_o    (viol[RULE_GAP])
  );

  xchk_watchdog #(.MAX_WAIT(MAX_WAIT)) u_wdog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_access_i (in_access_i),
    .pready_i    (pready_i),
    .hready_out_i(hready_out_i),
    .hang_o      (viol[RULE_HANG])
  );

  // sticky bank, clear wins over a same-cycle set
  for (genvar i = 0; i < NUM_RULES; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flags_o[i] <= 1'b0;
      else if (clr_i)   flags_o[i] <= 1'b0;
      else if (viol[i]) flags_o[i] <= 1'b1;
    end
  end

  assign any_o = |flags_o;
endmodule

// File: rtl/xchk_sva.sv
`timescale 1ns/1ps
module xchk_sva
  import xchk_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 clr_i,
  input logic                 in_access_i,
  input logic                 hready_out_i,
  input logic                 hresp_err_i,
  input logic                 pready_i,
  input logic                 pslverr_i,
  input logic [NUM_RULES-1:0] flags_o
);
  assert_wait_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_access_i && !pready_i && hready_out_i && !clr_i) |=> flags_o[RULE_WAIT]);

  assert_err_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_access_i && pready_i && pslverr_i && !hresp_err_i && !clr_i) |=> flags_o[RULE_ERR]);

  assert_clean_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_access_i && pready_i && !pslverr_i && hresp_err_i && !clr_i) |=> flags_o[RULE_CLEAN]);

  assert_hang_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[RULE_HANG]) |-> $past(in_access_i && !(pready_i && hready_out_i)));

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flags_o == '0));
endmodule

bind bridge_xchk xchk_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .in_access_i (in_access_i),
  .hready_out_i(hready_out_i),
  .hresp_err_i (hresp_err_i),
  .pready_i    (pready_i),
  .pslverr_i   (pslverr_i),
  .flags_o     (flags_o)
);

// File: tb/tb_bridge_xchk.sv
`timescale 1ns/1ps
module tb_bridge_xchk;
  localparam int AW = 8;
  localparam int MW = 5;
  localparam int NR = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic clr, acc, hro, herr, psel, pen, prdy, slv, wr;
  logic [AW-1:0] addr;
  logic [NR-1:0] flags;
  logic any;

  int tests = 0, fails = 0;

  // bench model state
  logic [NR-1:0] m_flags;
  logic m_armed, m_busy, m_wr;
  logic [AW-1:0] m_addr;
  int m_cnt;

  always #2.5 clk = ~clk;

  bridge_xchk #(.AW(AW), .MAX_WAIT(MW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .in_access_i(acc),
    .hready_out_i(hro), .hresp_err_i(herr), .psel_i(psel), .penable_i(pen),
    .pready_i(prdy), .pslverr_i(slv), .paddr_i(addr), .pwrite_i(wr),
    .flags_o(flags), .any_o(any)
  );

  function automatic logic [NR-1:0] rule_hits();
    logic [NR-1:0] v;
    logic stall;
    stall = acc && !(prdy && hro);
    v[0] = acc && !prdy && hro;
    v[1] = acc && prdy && slv && !herr;
    v[2] = acc && prdy && !slv && herr;
    v[3] = m_armed && m_busy && ((addr != m_addr) || (wr != m_wr));
    v[4] = m_armed && psel && !m_busy && pen;
    v[5] = stall && (m_cnt >= MW - 1);
    return v;
  endfunction

  task automatic model_reset();
    m_flags = '0; m_armed = 1'b0; m_busy = 1'b0; m_wr = 1'b0; m_addr = '0; m_cnt = 0;
  endtask

  task automatic idle();
    clr = 0; acc = 0; hro = 1; herr = 0; psel = 0; pen = 0; prdy = 0; slv = 0;
  endtask

  task automatic check(string tag, logic [NR-1:0] exp);
    tests++;
    if (flags !== exp || any !== (|exp)) begin
      fails++;
      $display("FAIL %s flags=%b any=%b expected flags=%b any=%b", tag, flags, any, exp, |exp);
    end
  endtask

  // one clock: model predicts, design is sampled 1 ns after the edge
  task automatic cyc(string tag);
    logic [NR-1:0] v;
    logic stall;
    v = rule_hits();
    stall = acc && !(prdy && hro);
    @(posedge clk);
    #1;
    m_flags = clr ? '0 : (m_flags | v);
    m_cnt   = stall ? ((m_cnt < MW - 1) ? m_cnt + 1 : m_cnt) : 0;
    m_armed = 1'b1;
    m_busy  = psel && !(pen && prdy);
    m_addr  = addr;
    m_wr    = wr;
    check(tag, m_flags);
  endtask

  task automatic clear();
    idle(); clr = 1; cyc("R8"); clr = 0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle(); addr = 8'h10; wr = 0;
    // R10: reset state, then select already enabled across release
    psel = 1; pen = 1;
    repeat (3) @(posedge clk);
    #1; model_reset(); check("R10", '0);
    rst_ni = 1;
    cyc("R10");                       // hold-off: no setup-gap flag
    idle(); cyc("R10");

    // R1 wait propagation
    acc = 1; prdy = 0; hro = 0; cyc("R1");
    hro = 1; cyc("R1");
    idle(); cyc("R7");                // stays set
    cyc("R9");
    clear();

    // R2 and R3 error mapping
    acc = 1; prdy = 1; slv = 1; herr = 1; cyc("R2");
    herr = 0; cyc("R2");
    idle(); clear();
    acc = 1; prdy = 1; slv = 0; herr = 0; cyc("R3");
    herr = 1; cyc("R3");
    idle(); clear();

    // R8 clear beats a same-cycle violation
    acc = 1; prdy = 0; hro = 1; clr = 1; cyc("R8");
    idle(); cyc("R8");

    // R4 capture: stable pass, change in flight, change after completion
    psel = 1; pen = 0; addr = 8'h20; wr = 1; cyc("R4");
    pen = 1; prdy = 0; cyc("R4");
    prdy = 1; cyc("R4");
    addr = 8'h24; wr = 0; pen = 0; prdy = 0; cyc("R4");   // new transfer after completion
    addr = 8'h28; pen = 1; cyc("R4");                     // moved while in flight
    idle(); clear();
    psel = 1; pen = 0; addr = 8'h30; wr = 0; cyc("R4");
    wr = 1; pen = 1; cyc("R4");
    idle(); clear();

    // R5 setup gap: from idle and straight after completion
    psel = 1; pen = 1; cyc("R5");
    idle(); clear();
    psel = 1; pen = 0; addr = 8'h40; cyc("R5");
    pen = 1; prdy = 1; cyc("R5");
    prdy = 0; cyc("R5");               // pen still high on next transfer
    idle(); clear();

    // R6 watchdog boundary
    acc = 1; hro = 0; prdy = 0;
    for (int i = 0; i < MW - 1; i++) cyc("R6");
    prdy = 1; hro = 1; cyc("R6");      // completes in time
    prdy = 0; hro = 0;
    for (int i = 0; i < MW - 2; i++) cyc("R6");
    idle(); cyc("R6");                 // leaving ACCESS restarts the count
    acc = 1; hro = 0;
    for (int i = 0; i < MW; i++) cyc("R6");   // MW stalls -> hang
    idle(); cyc("R6");
    clear();

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      clr  = ($urandom_range(0, 5) == 0);
      acc  = $urandom_range(0, 1);
      hro  = $urandom_range(0, 1);
      herr = ($urandom_range(0, 3) == 0);
      psel = $urandom_range(0, 1);
      pen  = $urandom_range(0, 1);
      prdy = $urandom_range(0, 1);
      slv  = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 7) == 0) addr = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 7) == 0) wr = ~wr;
      cyc("random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule